// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is the station-management master that a host uses to reach external Ethernet PHYs over the two-wire MDIO bus. Software first selects the framing style (Clause 22 or Clause 45) and whether a preamble is sent, using a configuration register. For writes and Clause 45 address cycles it then loads a 16-bit data word. Finally it writes a command word, and that write starts one frame on the wire. The block divides the system clock down to MDC, shifts the frame out MSB first and releases the data line for the turnaround of a read. It then captures the PHY's answer on the MDC rising edges.

Completion is not reported through a status register. Each data register carries its own busy flag. The write-data register shows a pending bit while a write or address frame is in progress. The read-data register shows a pending bit during a read, and afterwards a valid bit that qualifies the captured word. The meaning of the 2-bit operation field depends on the global framing-mode bit.

Top module: `mdio_master`

## Requirements
- R1: The block has four word registers, selected by `busAddr`. Address 0 is configuration: bit 0 selects Clause 45 framing (0 selects Clause 22), bit 1 enables the preamble, and the reset value is 0x2. Address 1 is write data: bits 15:0 hold the data word, bit 16 is the read-only pending flag, and the reset value is 0. Address 2 is read data: bits 15:0 hold the captured word, bit 16 is pending, bit 17 is valid, and the reset value is 0. Address 3 is the command register and is write-only: bits 1:0 hold the op, bits 6:2 the PHY address, bits 11:7 the register or device address. An accepted write to address 3 starts a frame on the same clock edge.
- R2: MDC is low while idle. During a frame, MDC stays low for CLK_HALF clocks and then high for CLK_HALF clocks for every bit. The first rising edge comes CLK_HALF clocks after the launching edge. The driven data changes only at the start of a bit, while MDC is low.
- R3: When preamble is enabled, every frame begins with 32 driven ones, which makes a write frame last 64 bit times (64·2·CLK_HALF clocks). When preamble is disabled, no preamble is sent and the frame lasts 32 bit times.
- R4: In Clause 22 mode the start field is 01. Op 0 is a write with wire opcode 01, and op 1 is a read with wire opcode 10. The opcode is followed MSB first by the 5-bit PHY address, the 5-bit register address, the turnaround (10 on writes) and the 16-bit data.
- R5: In Clause 45 mode the start field is 00 and the 5-bit register field carries the device address. Op 0 is an address frame with wire opcode 00, whose 16-bit payload is the write-data word. Op 1 is a write with opcode 01, and op 3 is a read with opcode 11.
- R6: On a read, MDIO output-enable drops at the first turnaround bit and stays low until the end of the frame. The 16 data bits are sampled at MDC rising edges. Valid is set, with the captured word, only if the second turnaround bit is sampled low.
- R7: The write-data pending flag is set from the launch of a write or address frame until that frame ends, and it is clear otherwise.
- R8: The read-data pending flag is set from the launch of a read until it ends, and launching a read clears valid.
- R9: A command written while either pending flag is set is ignored: the frame on the wire and the flags are unaffected, and no further frame follows.
- R10: Unsupported op values (2 and 3 in Clause 22, and 2 in Clause 45) start no frame and set no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register select |
| busWrEn | input | 1 | Register write strobe |
| busWrData | input | 32 | Register write data |
| busRdData | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock to the PHYs |
| mdioOe | output | 1 | Output enable for the MDIO pad |
| mdioOut | output | 1 | Value driven on MDIO when enabled |
| mdioIn | input | 1 | Value seen on the MDIO pad |

## Verification
The hardest situation to reach is a command that arrives in the middle of a running frame, which must leave no mark on the wire. The bench launches a read, waits until the frame is well into its address bits, and then writes a second command. A per-clock reference model then compares every MDC, enable and data bit against the undisturbed frame, and it keeps checking the idle bus afterwards. A second hard case is a PHY that does not pull the second turnaround bit low. The bench responder is steered to leave that bit high on one read, placed directly after a good read, so that the clearing of valid at launch and its staying clear at completion are both observed.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  // register select values
  localparam logic [1:0] REG_CFG   = 2'd0;
  localparam logic [1:0] REG_WDATA = 2'd1;
  localparam logic [1:0] REG_RDATA = 2'd2;
  localparam logic [1:0] REG_CMD   = 2'd3;

  localparam int FRAME_BITS = 32;
  localparam int DATA_W     = 16;
  localparam int TA_IDX     = 14;  // first turnaround bit inside the frame
  localparam int DATA_IDX   = 16;  // first data bit inside the frame

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic shift;
    logic sampleTa;
    logic sampleData;
    logic finish;
    logic preamble;
  } mdioStrobes_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int CLK_HALF = 4,
  parameter int PRE_BITS = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdGo,
  input  logic         cmdRead,
  input  logic         preEn,
  output logic         mdc,
  output logic         mdioOe,
  output mdioStrobes_t strobes
);
  localparam int DIV_W = $clog2(CLK_HALF + 1);
  localparam int CNT_W = $clog2(PRE_BITS + FRAME_BITS + 1);

  logic             running;
  logic             mdcQ;
  logic             readQ;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] preLen;
  logic [CNT_W-1:0] frameIdx;
  logic             inPre;
  logic             tick;
  logic             rise;
  logic             fall;
  logic             lastBit;

  assign inPre    = bitCnt < preLen;
  assign frameIdx = bitCnt - preLen;
  assign tick     = running && (divCnt == DIV_W'(CLK_HALF - 1));
  assign rise     = tick && !mdcQ;
  assign fall     = tick && mdcQ;
  assign lastBit  = bitCnt == (preLen + CNT_W'(FRAME_BITS - 1));

  always_comb begin
    strobes            = '0;
    strobes.load       = cmdGo && !running;
    strobes.shift      = fall && !inPre && !lastBit;
    strobes.sampleTa   = rise && readQ && !inPre && (frameIdx == CNT_W'(TA_IDX + 1));
    strobes.sampleData = rise && readQ && !inPre && (frameIdx >= CNT_W'(DATA_IDX));
    strobes.finish     = fall && lastBit;
    strobes.preamble   = inPre;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      mdcQ    <= 1'b0;
      readQ   <= 1'b0;
      divCnt  <= '0;
      bitCnt  <= '0;
      preLen  <= '0;
    end else if (strobes.load) begin
      running <= 1'b1;
      mdcQ    <= 1'b0;
      readQ   <= cmdRead;
      divCnt  <= '0;
      bitCnt  <= '0;
      preLen  <= preEn ? CNT_W'(PRE_BITS) : '0;
    end else if (running) begin
      if (tick) begin
        divCnt <= '0;
        mdcQ   <= ~mdcQ;
        if (fall) begin
          if (lastBit) running <= 1'b0;
          else         bitCnt  <= bitCnt + 1'b1;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign mdc    = mdcQ;
  assign mdioOe = running && !(readQ && !inPre && (frameIdx >= CNT_W'(TA_IDX)));

  // R2
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> !mdc);

  // R2
  mdc_half_period_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && !tick && !strobes.load) |=> $stable(mdc));

  // R6
  oe_release_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && readQ && !mdioOe) |=> (!mdioOe));
endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   busAddr,
  input  logic         busWrEn,
  input  logic [31:0]  busWrData,
  output logic [31:0]  busRdData,
  input  logic         mdioIn,
  input  mdioStrobes_t strobes,
  output logic         mdioOut,
  output logic         cmdGo,
  output logic         cmdRead,
  output logic         preEn
);
  logic                    cfgMode;
  logic                    cfgPre;
  logic [DATA_W-1:0]       wrData;
  logic [DATA_W-1:0]       rdData;
  logic [DATA_W-1:0]       capData;
  logic                    wrPend;
  logic                    rdPend;
  logic                    rdValid;
  logic                    taOk;
  logic [FRAME_BITS-1:0]   shiftReg;
  logic [FRAME_BITS-1:0]   frameWord;
  logic                    cmdWr;
  logic                    supported;
  logic                    isRead;
  logic [1:0]              wireSt;
  logic [1:0]              wireOp;
  logic                    busy;
  logic                    unusedHigh;

  assign unusedHigh = ^busWrData[31:16];
  assign cmdWr      = busWrEn && (busAddr == REG_CMD);
  assign busy       = wrPend || rdPend;

  // op decode depends on the global framing mode
  always_comb begin
    supported = 1'b1;
    isRead    = 1'b0;
    wireSt    = 2'b01;
    wireOp    = 2'b01;
    case ({cfgMode, busWrData[1:0]})
      3'b000: begin wireSt = 2'b01; wireOp = 2'b01; end
      3'b001: begin wireSt = 2'b01; wireOp = 2'b10; isRead = 1'b1; end
      3'b100: begin wireSt = 2'b00; wireOp = 2'b00; end
      3'b101: begin wireSt = 2'b00; wireOp = 2'b01; end
      3'b111: begin wireSt = 2'b00; wireOp = 2'b11; isRead = 1'b1; end
      default: supported = 1'b0;
    endcase
  end

  assign frameWord = {wireSt, wireOp, busWrData[6:2], busWrData[11:7],
                      isRead ? 2'b11 : 2'b10,
                      isRead ? {DATA_W{1'b1}} : wrData};
  assign cmdGo   = cmdWr && supported && !busy;
  assign cmdRead = isRead;
  assign preEn   = cfgPre;
  assign mdioOut = strobes.preamble ? 1'b1 : shiftReg[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgMode  <= 1'b0;
      cfgPre   <= 1'b1;
      wrData   <= '0;
      rdData   <= '0;
      capData  <= '0;
      wrPend   <= 1'b0;
      rdPend   <= 1'b0;
      rdValid  <= 1'b0;
      taOk     <= 1'b0;
      shiftReg <= '0;
    end else begin
      if (busWrEn && busAddr == REG_CFG) begin
        cfgMode <= busWrData[0];
        cfgPre  <= busWrData[1];
      end
      if (busWrEn && busAddr == REG_WDATA) wrData <= busWrData[DATA_W-1:0];
      if (strobes.load) begin
        shiftReg <= frameWord;
        taOk     <= 1'b0;
        if (isRead) begin
          rdPend  <= 1'b1;
          rdValid <= 1'b0;
        end else begin
          wrPend  <= 1'b1;
        end
      end else if (strobes.shift) begin
        shiftReg <= {shiftReg[FRAME_BITS-2:0], 1'b0};
      end
      if (strobes.sampleTa)   taOk    <= !mdioIn;
      if (strobes.sampleData) capData <= {capData[DATA_W-2:0], mdioIn};
      if (strobes.finish) begin
        wrPend <= 1'b0;
        if (rdPend) begin
          rdPend  <= 1'b0;
          rdValid <= taOk;
          rdData  <= capData;
        end
      end
    end
  end

  always_comb begin
    case (busAddr)
      REG_CFG:   busRdData = {30'd0, cfgPre, cfgMode};
      REG_WDATA: busRdData = {15'd0, wrPend, wrData};
      REG_RDATA: busRdData = {14'd0, rdValid, rdPend, rdData};
      default:   busRdData = '0;
    endcase
  end

  // R7 R8
  pend_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrPend && rdPend));

  // R8
  valid_not_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdPend |-> !rdValid);

  // R9
  busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && busy && !strobes.finish) |=> ($stable(wrPend) && $stable(rdPend)));

  // R6
  sample_in_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.sampleData || strobes.sampleTa) |-> rdPend);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int CLK_HALF = 4,
  parameter int PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  busAddr,
  input  logic        busWrEn,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  output logic        mdc,
  output logic        mdioOe,
  output logic        mdioOut,
  input  logic        mdioIn
);
  mdioStrobes_t strobes;
  logic         cmdGo;
  logic         cmdRead;
  logic         preEn;

  mdio_ctrl #(.CLK_HALF(CLK_HALF), .PRE_BITS(PRE_BITS)) i_ctrl (
    .clk(clk), .rstN(rstN), .cmdGo(cmdGo), .cmdRead(cmdRead), .preEn(preEn),
    .mdc(mdc), .mdioOe(mdioOe), .strobes(strobes)
  );

  mdio_datapath i_datapath (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .mdioIn(mdioIn),
    .strobes(strobes), .mdioOut(mdioOut), .cmdGo(cmdGo), .cmdRead(cmdRead),
    .preEn(preEn)
  );
endmodule

// File: tb/test_mdio_master.sv
module test_mdio_master;
  localparam int HALF = 4;
  localparam int BITT = 2 * HALF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        mdc, mdioOe, mdioOut;
  logic        mdioIn = 1'b1;

  mdio_master #(.CLK_HALF(HALF), .PRE_BITS(32)) i_mdio_master (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .mdc(mdc),
    .mdioOe(mdioOe), .mdioOut(mdioOut), .mdioIn(mdioIn)
  );

  always #10 clk = ~clk;  // 50 MHz

  int nChecks = 0;
  int nFail   = 0;
  int cycles  = 0;

  // behavioural reference model
  bit          mActive = 0;
  int          mT, mLen, mPreLen;
  bit          mIsRead;
  bit          mBits[$];
  string       mReq = "R4";
  logic        mWrPend, mRdPend, mRdValid, mMode, mPre;
  logic [15:0] mWrData, mRdData;
  logic [15:0] phyData = 16'h0;
  logic        phyTa = 1'b0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  task automatic modelLaunch(logic [31:0] d);
    logic [1:0] st, op;
    bit ok, rd;
    logic [31:0] w;
    ok = 1; rd = 0; st = 2'b01; op = 2'b01;
    case ({mMode, d[1:0]})
      3'b000: begin st = 2'b01; op = 2'b01; end
      3'b001: begin st = 2'b01; op = 2'b10; rd = 1; end
      3'b100: begin st = 2'b00; op = 2'b00; end
      3'b101: begin st = 2'b00; op = 2'b01; end
      3'b111: begin st = 2'b00; op = 2'b11; rd = 1; end
      default: ok = 0;
    endcase
    if (!ok) return;
    w = {st, op, d[6:2], d[11:7], rd ? 2'b11 : 2'b10, rd ? 16'hFFFF : mWrData};
    mBits.delete();
    mPreLen = mPre ? 32 : 0;
    for (int i = 0; i < mPreLen; i++) mBits.push_back(1'b1);
    for (int i = 31; i >= 0; i--) mBits.push_back(w[i]);
    mLen = mBits.size() * BITT;
    mT = 0; mActive = 1; mIsRead = rd;
    mReq = mMode ? "R5" : "R4";
    if (rd) begin mRdPend = 1; mRdValid = 0; end
    else mWrPend = 1;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mActive = 0; mWrPend = 0; mRdPend = 0; mRdValid = 0;
      mMode = 0; mPre = 1; mWrData = 0; mRdData = 0;
    end else begin
      bit busyBefore;
      busyBefore = mWrPend || mRdPend;
      if (mActive) begin
        if (mT == mLen - 1) begin
          mActive = 0;
          if (mRdPend) begin mRdValid = (phyTa == 1'b0); mRdData = phyData; end
          mWrPend = 0; mRdPend = 0;
        end else mT++;
      end
      if (busWrEn) begin
        case (busAddr)
          2'd0: begin mMode = busWrData[0]; mPre = busWrData[1]; end
          2'd1: mWrData = busWrData[15:0];
          2'd3: if (!busyBefore) modelLaunch(busWrData);
          default: ;
        endcase
      end
    end
  end

  // PHY responder and per-clock comparison, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
    mdioIn = 1'b1;
    if (rstN && mActive && mIsRead) begin
      int fi;
      fi = mT / BITT - mPreLen;
      if (fi == 15) mdioIn = phyTa;
      else if (fi >= 16) mdioIn = phyData[31 - fi];
    end
    if (rstN) begin
      bit expMdc, expOe;
      int b;
      b = mT / BITT;
      expMdc = mActive && ((mT / HALF) % 2 == 1);
      expOe  = mActive && !(mIsRead && (b - mPreLen) >= 14);
      check("R2 mdc", {31'd0, mdc}, {31'd0, expMdc});
      check("R6 R9 oe", {31'd0, mdioOe}, {31'd0, expOe});
      if (expOe) begin
        if (b < mPreLen) check("R3 preamble bit", {31'd0, mdioOut}, {31'd0, mBits[b]});
        else             check({mReq, " frame bit"}, {31'd0, mdioOut}, {31'd0, mBits[b]});
      end
    end
  end

  function automatic logic [31:0] cmdWord(logic [1:0] op, logic [4:0] phy, logic [4:0] rg);
    return {20'd0, rg, phy, op};
  endfunction

  task automatic wr(logic [1:0] a, logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic checkReg(string req, logic [1:0] a, logic [31:0] exp);
    busAddr = a; #1;
    check(req, busRdData, exp);
  endtask

  task automatic waitDone(logic [1:0] a, int pos, output int n);
    busAddr = a; #1;
    n = 0;
    while (busRdData[pos] && n < 3000) begin
      @(negedge clk); #1;
      n++;
    end
  endtask

  function automatic logic [31:0] modelRd();
    return {14'd0, mRdValid, mRdPend, mRdData};
  endfunction

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1 reset mdc/oe", {30'd0, mdc, mdioOe}, 32'd0);
    checkReg("R1 reset cfg", 2'd0, 32'h2);
    checkReg("R1 reset wdata", 2'd1, 32'h0);
    checkReg("R1 reset rdata", 2'd2, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // Clause 22 write with preamble
    wr(2'd1, 32'hA5C3);
    wr(2'd3, cmdWord(2'd0, 5'd5, 5'd3));
    checkReg("R7 write pending set", 2'd1, 32'h0001_A5C3);
    waitDone(2'd1, 16, n);
    check("R3 frame length with preamble", n, 64 * BITT);
    checkReg("R7 write pending clear", 2'd1, 32'h0000_A5C3);

    // Clause 22 read, good turnaround
    phyData = 16'h1234; phyTa = 1'b0;
    wr(2'd3, cmdWord(2'd1, 5'd9, 5'd17));
    checkReg("R8 read pending", 2'd2, 32'h0001_0000);
    waitDone(2'd2, 16, n);
    checkReg("R6 read valid data", 2'd2, 32'h0002_1234);

    // Clause 22 read, PHY leaves turnaround high
    phyData = 16'hBEEF; phyTa = 1'b1;
    wr(2'd3, cmdWord(2'd1, 5'd1, 5'd2));
    checkReg("R8 valid cleared at launch", 2'd2, 32'h0001_1234);
    waitDone(2'd2, 16, n);
    checkReg("R6 no valid on bad turnaround", 2'd2, 32'h0000_BEEF);

    // R9: command while a read is pending
    phyData = 16'h0F0F; phyTa = 1'b0;
    wr(2'd3, cmdWord(2'd1, 5'd30, 5'd4));
    repeat (40 * BITT) @(negedge clk);
    wr(2'd3, cmdWord(2'd0, 5'd7, 5'd7));
    checkReg("R9 no write pending from ignored cmd", 2'd1, 32'h0000_A5C3);
    waitDone(2'd2, 16, n);
    checkReg("R9 read unaffected", 2'd2, 32'h0002_0F0F);
    repeat (4 * BITT) @(negedge clk);
    check("R9 no follow-on frame", {31'd0, mdc}, 32'd0);
    checkReg("R9 wdata idle", 2'd1, 32'h0000_A5C3);

    // R10: unsupported Clause 22 ops
    wr(2'd3, cmdWord(2'd2, 5'd1, 5'd1));
    repeat (3 * HALF) @(negedge clk);
    check("R10 c22 op2 no frame", {30'd0, mdc, mdioOe}, 32'd0);
    wr(2'd3, cmdWord(2'd3, 5'd1, 5'd1));
    checkReg("R10 c22 op3 no read pending", 2'd2, 32'h0002_0F0F);

    // Clause 45, preamble off
    wr(2'd0, 32'h1);
    checkReg("R1 cfg readback", 2'd0, 32'h1);
    wr(2'd1, 32'h8001);
    wr(2'd3, cmdWord(2'd0, 5'd2, 5'd7));
    checkReg("R5 R7 address pending", 2'd1, 32'h0001_8001);
    waitDone(2'd1, 16, n);
    check("R3 frame length without preamble", n, 32 * BITT);
    wr(2'd1, 32'h00FF);
    wr(2'd3, cmdWord(2'd1, 5'd2, 5'd7));
    waitDone(2'd1, 16, n);
    checkReg("R5 write done", 2'd1, 32'h0000_00FF);
    phyData = 16'hC0DE; phyTa = 1'b0;
    wr(2'd3, cmdWord(2'd3, 5'd2, 5'd7));
    checkReg("R5 read pending", 2'd2, modelRd());
    waitDone(2'd2, 16, n);
    checkReg("R5 R6 c45 read data", 2'd2, 32'h0002_C0DE);
    wr(2'd3, cmdWord(2'd2, 5'd2, 5'd7));
    repeat (3 * HALF) @(negedge clk);
    check("R10 c45 op2 no frame", {30'd0, mdc, mdioOe}, 32'd0);
    checkReg("R10 c45 op2 no flags", 2'd2, 32'h0002_C0DE);

    // Clause 45 read with preamble
    wr(2'd0, 32'h3);
    phyData = 16'h5A5A;
    wr(2'd3, cmdWord(2'd3, 5'd31, 5'd1));
    waitDone(2'd2, 16, n);
    check("R3 R6 read length with preamble", n, 64 * BITT);
    checkReg("R6 c45 read with preamble", 2'd2, modelRd());

    repeat (10) @(negedge clk);
    summary();
    $finish;
  end
endmodule